// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block runs the bus transaction that collects an interrupt vector from an external cascadable interrupt controller. When the internal interrupt unit raises a request, the sequencer issues two back-to-back acknowledge cycles. Each has the same state-by-state timing as a read cycle, but it pulses a dedicated acknowledge strobe and leaves the read strobe inactive. A bus-lock output stays high across both cycles so that no other master can take the bus between them.

Only the second cycle carries the vector. The sequencer registers the low eight data bits at the moment that cycle's strobe ends with ready high. On a 16-bit bus the upper byte is neither driven nor sampled. After the lock drops, the vector is presented to the CPU side together with a one-clock valid pulse. Ready is sampled at the end of the third state of every cycle, and each low sample inserts one wait state. A second bus master asks for the bus through a request/grant pair. The grant is only given while the sequencer is idle and no acknowledge request is pending.

Top module: `intack_seq`

## Requirements
- R1: After reset, and immediately after reset is asserted at any point in a sequence: ack_stb_n=1, read_stb_n=1, bus_locked=0, vec_valid=0, vec_out=0.
- R2: An ack_req sampled high while idle makes bus_locked high from the next clock (state T1). ack_stb_n then goes low in the following clock (T2) and stays low for at least two clocks.
- R3: Exactly two ack_stb_n low pulses occur per sequence. Between them the strobe is high for GAP_CYC+2 clocks: T4, GAP_CYC idle clocks (default 1), and T1.
- R4: read_stb_n stays high at all times.
- R5: bus_locked stays high without a break from the first cycle's T1 through the second cycle's T4, and falls in the clock after the second T4.
- R6: Each ready-low sample at the end of T3 (or of a wait state) lengthens that strobe pulse by one clock. With ready high the pulse lasts two clocks.
- R7: vec_out equals bus_din[7:0] as sampled on the clock edge that ends the second pulse with ready high. The first cycle's data and bus_din[15:8] have no effect.
- R8: vec_valid is high for exactly one clock, the first clock with bus_locked low after the second cycle. vec_out keeps its value until the next capture.
- R9: alt_gnt equals alt_req only while the sequencer is idle and ack_req is low. Otherwise it is 0, in particular whenever bus_locked is high.
- R10: ack_req is only sampled while idle. A request raised during a sequence is dropped and starts no further sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Vector fetch request from the interrupt unit |
| bus_ready | input | 1 | Bus ready, sampled at the end of T3 and of wait states |
| bus_din | input | DATA_W | Data bus input |
| alt_req | input | 1 | Bus request from another master |
| read_stb_n | output | 1 | Read strobe, active low (always inactive here) |
| ack_stb_n | output | 1 | Acknowledge strobe, active low |
| bus_locked | output | 1 | Bus lock covering both acknowledge cycles |
| alt_gnt | output | 1 | Bus grant to the other master |
| vec_out | output | VEC_W | Captured interrupt vector |
| vec_valid | output | 1 | One-clock pulse: vec_out holds a new vector |

## Verification
A corrupted cycle state shows at ack_stb_n within one clock. The pulse starts early or late, or its width no longer tracks the count of ready-low samples. A wrong sequence state appears as a third pulse, a missing pulse, or a gap between the pulses that differs from GAP_CYC+2. It can also appear as a break in bus_locked or a grant issued during a sequence, and all of these are visible before the sequence ends. A capture fault lets first-cycle data or data after the strobe edge reach vec_out. It is seen in the clock where vec_valid pulses, which also shows whether that pulse came one clock after the lock dropped.

// File: rtl/intack_pkg.sv
package intack_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_TW,
        PH_T4
    } phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CYC1,
        SQ_GAP,
        SQ_CYC2,
        SQ_FIN
    } seq_e;

endpackage

// File: rtl/intack_cycle.sv
module intack_cycle
    import intack_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   rdy,
    output phase_e phase,
    output logic   stb_n,
    output logic   sample,
    output logic   done
);

    typedef struct packed {
        phase_e ph;
        logic   stb_n;
    } cyc_t;

    cyc_t cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_q;
        unique case (cyc_q.ph)
            PH_IDLE: if (start) cyc_d.ph = PH_T1;
            PH_T1:   cyc_d.ph = PH_T2;
            PH_T2:   cyc_d.ph = PH_T3;
            PH_T3,
            PH_TW:   cyc_d.ph = rdy ? PH_T4 : PH_TW;
            PH_T4:   cyc_d.ph = PH_IDLE;
            default: cyc_d.ph = PH_IDLE;
        endcase
        cyc_d.stb_n = !(cyc_d.ph == PH_T2 || cyc_d.ph == PH_T3 || cyc_d.ph == PH_TW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q.ph    <= PH_IDLE;
            cyc_q.stb_n <= 1'b1;
        end else begin
            cyc_q <= cyc_d;
        end
    end

    assign phase  = cyc_q.ph;
    assign stb_n  = cyc_q.stb_n;
    assign sample = (cyc_q.ph == PH_T3 || cyc_q.ph == PH_TW) && rdy;
    assign done   = (cyc_q.ph == PH_T4);

    AST_STROBE_TWO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_n) |=> !stb_n); // R2

endmodule

// File: rtl/intack_ctrl.sv
module intack_ctrl
    import intack_pkg::*;
#(
    parameter int GAP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_req,
    input  logic cyc_done,
    output logic start,
    output logic lock,
    output logic second,
    output logic publish,
    output logic idle
);

    localparam int GW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_e          st;
        logic [GW-1:0] gap;
        logic          lock;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d  = sq_q;
        start = 1'b0;
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (ack_req) begin
                    sq_d.st   = SQ_CYC1;
                    sq_d.lock = 1'b1;
                    start     = 1'b1;
                end
            end
            SQ_CYC1: begin
                if (cyc_done) begin
                    sq_d.st  = SQ_GAP;
                    sq_d.gap = GW'(GAP_CYC - 1);
                end
            end
            SQ_GAP: begin
                if (sq_q.gap == '0) begin
                    sq_d.st = SQ_CYC2;
                    start   = 1'b1;
                end else begin
                    sq_d.gap = sq_q.gap - 1'b1;
                end
            end
            SQ_CYC2: begin
                if (cyc_done) begin
                    sq_d.st   = SQ_FIN;
                    sq_d.lock = 1'b0;
                end
            end
            SQ_FIN:  sq_d.st = SQ_IDLE;
            default: begin
                sq_d.st   = SQ_IDLE;
                sq_d.lock = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q.st   <= SQ_IDLE;
            sq_q.gap  <= '0;
            sq_q.lock <= 1'b0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign lock    = sq_q.lock;
    assign second  = (sq_q.st == SQ_CYC2);
    assign publish = (sq_q.st == SQ_FIN);
    assign idle    = (sq_q.st == SQ_IDLE);

    AST_LOCK_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(ack_req)); // R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !publish) |=> !publish || $past(second)); // R10

endmodule

// File: rtl/intack_vec.sv
module intack_vec #(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [VEC_W-1:0]  vec
);

    logic [VEC_W-1:0] vec_d, vec_q;

    always_comb begin
        vec_d = vec_q;
        if (cap_en) vec_d = din[VEC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    generate
        if (DATA_W > VEC_W) begin : g_upper
            logic unused_upper;
            assign unused_upper = ^din[DATA_W-1:VEC_W];
        end
    endgenerate

    assign vec = vec_q;

endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int VEC_W   = 8,
    parameter int GAP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              alt_req,
    output logic              read_stb_n,
    output logic              ack_stb_n,
    output logic              bus_locked,
    output logic              alt_gnt,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid
);

    phase_e phase;
    logic   cyc_start, cyc_sample, cyc_done;
    logic   seq_second, seq_publish, seq_idle;

    intack_ctrl #(.GAP_CYC(GAP_CYC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_req  (ack_req),
        .cyc_done (cyc_done),
        .start    (cyc_start),
        .lock     (bus_locked),
        .second   (seq_second),
        .publish  (seq_publish),
        .idle     (seq_idle)
    );

    intack_cycle u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cyc_start),
        .rdy    (bus_ready),
        .phase  (phase),
        .stb_n  (ack_stb_n),
        .sample (cyc_sample),
        .done   (cyc_done)
    );

    intack_vec #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cyc_sample && seq_second),
        .din    (bus_din),
        .vec    (vec_out)
    );

    assign read_stb_n = 1'b1;
    assign vec_valid  = seq_publish;
    assign alt_gnt    = alt_req && seq_idle && !ack_req;

    AST_STB_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_stb_n |-> bus_locked); // R5

    AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        alt_gnt |-> !bus_locked); // R9

    AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid); // R8

    AST_VALID_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($past(bus_locked) && !bus_locked)); // R8

    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $stable(vec_out)); // R7

    AST_T1_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |-> bus_locked); // R5

endmodule

// File: tb/intack_seq_tb.sv
module intack_seq_tb;

    localparam int DATA_W = 16;
    localparam int VEC_W  = 8;
    localparam int GAP    = 1;
    localparam int NTBL   = 5;

    // {first data, second data, waits cycle 1, waits cycle 2}
    localparam logic [39:0] STIM [NTBL] = '{
        {16'h1234, 16'hAB5C, 4'd0, 4'd0},
        {16'h00FF, 16'hFF01, 4'd1, 4'd0},
        {16'hA5A5, 16'h7E80, 4'd0, 4'd2},
        {16'h5555, 16'hC3E7, 4'd3, 4'd1},
        {16'hFFFF, 16'h9900, 4'd2, 4'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ack_req = 1'b0;
    logic              bus_ready = 1'b0;
    logic [DATA_W-1:0] bus_din = '0;
    logic              alt_req = 1'b0;
    logic              read_stb_n, ack_stb_n, bus_locked, alt_gnt, vec_valid;
    logic [VEC_W-1:0]  vec_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    intack_seq #(.DATA_W(DATA_W), .VEC_W(VEC_W), .GAP_CYC(GAP)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_req    (ack_req),
        .bus_ready  (bus_ready),
        .bus_din    (bus_din),
        .alt_req    (alt_req),
        .read_stb_n (read_stb_n),
        .ack_stb_n  (ack_stb_n),
        .bus_locked (bus_locked),
        .alt_gnt    (alt_gnt),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        check({tag, " ack_stb_n"},  int'(ack_stb_n), 1);
        check({tag, " read_stb_n"}, int'(read_stb_n), 1);
        check({tag, " bus_locked"}, int'(bus_locked), 0);
        check({tag, " vec_valid"},  int'(vec_valid), 0);
        check({tag, " vec_out"},    int'(vec_out), 0);
    endtask

    task automatic run_seq(input logic [15:0] d1, input logic [15:0] d2,
                           input int w1, input int w2);
        int pulses = 0, idx = 0, f1 = -1, r1 = -1, f2 = -1, r2 = -1;
        int lrise = -1, lfall = -1, relock = 0, vcnt = 0, vclk = -1;
        int rd_bad = 0, gfirst = -1;
        logic prev = 1'b1;
        logic [7:0] vseen = '0;
        @(negedge clk);
        ack_req   = 1'b1;
        alt_req   = 1'b1;
        bus_din   = d1;
        bus_ready = 1'b0;
        #1;
        check("R9 grant withheld while request pending", int'(alt_gnt), 0);
        for (int c = 1; c <= 20 + w1 + w2; c++) begin
            @(negedge clk);
            if (!read_stb_n) rd_bad++;
            if (bus_locked && lrise < 0) lrise = c;
            if (!bus_locked && lrise >= 0 && lfall < 0) lfall = c;
            if (bus_locked && lfall >= 0) relock++;
            if (alt_gnt && gfirst < 0) gfirst = c;
            if (!ack_stb_n && prev) begin
                pulses++;
                idx = 0;
                if (pulses == 1) f1 = c;
                if (pulses == 2) f2 = c;
            end
            if (ack_stb_n && !prev) begin
                if (pulses == 1) r1 = c;
                if (pulses == 2) r2 = c;
            end
            if (!ack_stb_n) idx++;
            prev = ack_stb_n;
            if (vec_valid) begin
                vcnt++;
                vclk  = c;
                vseen = vec_out;
            end
            if (c == 1) ack_req = 1'b0;
            bus_ready = !ack_stb_n && (idx >= 2 + ((pulses == 1) ? w1 : w2));
            bus_din   = (pulses < 2) ? d1 : (!ack_stb_n ? d2 : ~d2);
        end
        alt_req = 1'b0;
        check("R2 lock rises one clock after request", lrise, 1);
        check("R2 first strobe falls in T2", f1, 2);
        check("R6 first strobe width with waits", r1, 4 + w1);
        check("R3 second strobe fall after gap", f2, 6 + w1 + GAP);
        check("R6 second strobe width with waits", r2, 8 + w1 + GAP + w2);
        check("R3 exactly two strobe pulses", pulses, 2);
        check("R5 lock falls after second T4", lfall, 9 + w1 + GAP + w2);
        check("R5 lock unbroken, no relock", relock, 0);
        check("R8 one valid pulse", vcnt, 1);
        check("R8 valid in first unlocked clock", vclk, lfall);
        check("R7 vector from second cycle low byte", int'(vseen), int'(d2[7:0]));
        check("R4 read strobe stays high", rd_bad, 0);
        check("R9 first grant after sequence", gfirst, lfall + 1);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rises;
        logic prev_lk;

        // R1 reset state
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // R9 grant follows request while idle
        alt_req = 1'b1;
        #1;
        check("R9 idle grant follows request", int'(alt_gnt), 1);
        alt_req = 1'b0;
        #1;
        check("R9 idle grant drops", int'(alt_gnt), 0);

        // table of stimulus vectors
        for (int i = 0; i < NTBL; i++) begin
            run_seq(STIM[i][39:24], STIM[i][23:8], int'(STIM[i][7:4]), int'(STIM[i][3:0]));
            repeat (2) @(negedge clk);
        end

        // R10 request raised during a sequence is dropped
        bus_ready = 1'b1;
        bus_din   = 16'hEE42;
        rises     = 0;
        prev_lk   = 1'b0;
        @(negedge clk);
        ack_req = 1'b1;
        for (int c = 1; c <= 30; c++) begin
            @(negedge clk);
            if (bus_locked && !prev_lk) rises++;
            prev_lk = bus_locked;
            ack_req = (c == 4);
        end
        check("R10 mid-sequence request dropped", rises, 1);
        check("R10 idle at end", int'(bus_locked), 0);

        // R8 vector held after valid
        repeat (5) @(negedge clk);
        check("R8 vector held", int'(vec_out), 8'h42);
        check("R8 valid low while holding", int'(vec_valid), 0);

        // R1 reset in the middle of a strobe
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req   = 1'b0;
        bus_ready = 1'b0;
        @(negedge clk);
        check("R1 strobe low before reset", int'(ack_stb_n), 0);
        rst_n = 1'b0;
        #1;
        check_idle("R1 mid-sequence reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after mid-sequence reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule